// File: doc/BRIEF.md
# Fixed-Period Motor PWM Generator

This block makes the speed-control waveform for one DC motor channel. It runs directly on a slow tick clock and produces a repeating frame of twenty ticks. A 5-bit high-time setting chooses how much of each frame the output spends high. With a 1 kHz tick, one frame lasts 20 ms.

Inside each frame a counter steps from 0 to 19 and then returns to 0. The setting is first limited to at most 20. It is then turned into a threshold equal to 20 minus the limited setting. The output goes high on every tick whose count lies strictly above that threshold.

An enable input gates the channel. At the system level this enable is a push-button combined with a stored per-motor enable bit. While the enable is low, the output stays low and the counter is parked at zero, so the next enabled frame starts from its beginning.

Top module: `pwm_speed_gen`

## Requirements
- R1: While rst_ni is low, pwm_o is low. The first enabled tick after reset is evaluated with a count of 0.
- R2: While en_i is high, the internal count steps through 0, 1, …, 19 and then back to 0, so the output pattern repeats every 20 ticks.
- R3: A high_time_i value above 20 (21 to 31) behaves exactly like 20: it gives 19 high ticks in every 20-tick frame.
- R4: The threshold is 20 minus the limited setting. The registered output is high for a tick exactly when the count is strictly greater than the threshold. For a setting h between 1 and 20, that gives h−1 high ticks per frame.
- R5: A tick sampled with en_i low drives pwm_o low and resets the count to 0. After en_i returns high, the first enabled tick is evaluated with a count of 0.
- R6: pwm_o comes from a register. The value set up by the count during one tick appears after that tick's rising clock edge, and stays constant until the next edge.
- R7: Boundary settings: a setting of 0 or 1 keeps pwm_o low all the time, and a setting of 20 holds pwm_o high on every count from 1 to 19.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock; one edge per PWM step |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; low parks the counter and holds the output low |
| high_time_i | input | 5 | High-time setting, limited internally to 20 |
| pwm_o | output | 1 | Registered PWM drive |

## Verification
Every result of this block is due exactly one tick edge after the inputs it depends on. The comparison for a given count is taken at a rising edge and shows on pwm_o straight after that edge. A disable seen at an edge clears both the output and the phase at that same edge.

The bench drives its inputs on falling edges. It advances its reference model at the rising edge, using the count the model held before that edge, and compares pwm_o on the following falling edge. Every prediction is therefore checked half a tick after it becomes due, and before any new stimulus is applied.

The high-tick count for each frame is also checked over a full window of 20 samples. Because the window covers a whole period, that count does not depend on where the frame starts.

// File: rtl/pwm_speed_pkg.sv
package pwm_speed_pkg;
  localparam int unsigned DEF_PERIOD = 20;
  localparam int unsigned DEF_SET_W  = 5;

  // bits needed to hold values 0..n-1
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pwm_thresh.sv
module pwm_thresh #(
  parameter int unsigned PERIOD = 20,
  parameter int unsigned SET_W  = 5,
  parameter int unsigned THR_W  = 5
) (
  input  logic [SET_W-1:0] high_time_i,
  output logic [THR_W-1:0] thr_o
);
  logic [THR_W-1:0] lim;

  generate
    if ((2 ** SET_W) - 1 > PERIOD) begin : g_clamp
      always_comb begin
        if (high_time_i > SET_W'(PERIOD)) lim = THR_W'(PERIOD);
        else                              lim = THR_W'(high_time_i);
      end
    end else begin : g_pass
      assign lim = THR_W'(high_time_i);
    end
  endgenerate

  assign thr_o = THR_W'(PERIOD) - lim;

  // R3
  always_comb begin
    thr_in_range_chk: assert (thr_o <= THR_W'(PERIOD) || $isunknown(high_time_i));
  end
endmodule

// File: rtl/pwm_phase_cnt.sv
module pwm_phase_cnt #(
  parameter int unsigned PERIOD = 20,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == LAST) |=> cnt_q == '0);

  // R5
  cnt_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned THR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= en_i && (THR_W'(cnt_i) > thr_i);
  end

  assign pwm_o = pwm_q;

  // R5
  pwm_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_q);

  // R7
  pwm_first_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> !pwm_q);
endmodule

// File: rtl/pwm_speed_gen.sv
module pwm_speed_gen
  import pwm_speed_pkg::*;
#(
  parameter int unsigned PERIOD = DEF_PERIOD,
  parameter int unsigned SET_W  = DEF_SET_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SET_W-1:0] high_time_i,
  output logic             pwm_o
);
  localparam int unsigned CNT_W = idx_w(PERIOD);
  localparam int unsigned THR_W = idx_w(PERIOD + 1);

  logic [CNT_W-1:0] cnt;
  logic [THR_W-1:0] thr;

  pwm_thresh #(.PERIOD(PERIOD), .SET_W(SET_W), .THR_W(THR_W)) u_thresh (
    .high_time_i(high_time_i),
    .thr_o      (thr)
  );

  pwm_phase_cnt #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .cnt_o (cnt)
  );

  pwm_out_stage #(.CNT_W(CNT_W), .THR_W(THR_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .cnt_i (cnt),
    .thr_i (thr),
    .pwm_o (pwm_o)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni || !pwm_o));
endmodule

// File: tb/pwm_speed_gen_test.sv
module pwm_speed_gen_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0;
  logic [4:0] ht = '0;
  logic       pwm;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  bit m_exp = 1'b0;
  string tag = "R1";
  bit done = 1'b0;

  pwm_speed_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .high_time_i(ht), .pwm_o(pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  always @(posedge clk) begin
    int h;
    if (!rst_ni || !en) begin
      m_exp = 1'b0;
      m_cnt = 0;
    end else begin
      h = (ht > 20) ? 20 : int'(ht);
      m_exp = (m_cnt > 20 - h);
      m_cnt = (m_cnt + 1) % 20;
    end
  end

  // per-tick comparison (R6 latency: one edge)
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pwm !== m_exp) begin
        errors++;
        $display("FAIL %s/R6: pwm_o=%b expected %b at %0t", tag, pwm, m_exp, $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic window(input logic [4:0] s, input int exp_hi, input string req);
    int hi = 0;
    tag = req;
    en = 1'b1;
    ht = s;
    repeat (40) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm === 1'b1) hi++;
    end
    chk(req, hi, exp_hi);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    en = 1'b1;
    ht = 5'd20;
    repeat (3) @(negedge clk);
    chk("R1", int'(pwm), 0);
    rst_ni = 1'b1;
    // R1: first enabled tick uses count 0, so the first high appears after the second edge
    @(negedge clk);
    chk("R1", int'(pwm), 0);
    @(negedge clk);
    chk("R1", int'(pwm), 1);
    tag = "R2";
    repeat (60) @(negedge clk);
    window(5'd20, 19, "R7");
    window(5'd31, 19, "R3");
    window(5'd21, 19, "R3");
    window(5'd10, 9, "R4");
    window(5'd5, 4, "R4");
    window(5'd2, 1, "R4");
    window(5'd0, 0, "R7");
    window(5'd1, 0, "R7");
    // R5: drop enable mid frame
    tag = "R5";
    ht = 5'd15;
    repeat (13) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R5", int'(pwm), 0);
    repeat (4) @(negedge clk);
    en = 1'b1;
    // restart from count 0: counts 0..5 low (threshold 5), count 6 high
    repeat (6) @(negedge clk);
    chk("R5", int'(pwm), 0);
    @(negedge clk);
    chk("R5", int'(pwm), 1);
    // R6: output stable within a tick
    tag = "R6";
    @(posedge clk);
    #1;
    begin
      logic v;
      v = pwm;
      #(CLK_PERIOD/2 - 2);
      chk("R6", int'(pwm), int'(v));
    end
    // live setting change while running
    tag = "R4";
    ht = 5'd8;
    repeat (30) @(negedge clk);
    // reset in the middle
    tag = "R1";
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", int'(pwm), 0);
    rst_ni = 1'b1;
    repeat (40) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule